// File: doc/BRIEF.md
# Transmit Elastic Store with Bursty System Clock

This block sits between a system-side serial source and a 2.048 MHz E1 transmit line. The system side writes one bit for every cycle in which its data-valid strobe is high, on a fast system clock. That lets a gapped or bursty source with instantaneous rates of up to four times the line rate feed the store. A system frame sync, qualified by the strobe, marks the first bit of every written frame. The line side reads one bit per line clock and outputs a frame-start pulse with each 256-bit frame.

Storage is two 256-bit frame banks. The write side signals each completed frame to the line domain through a Gray-coded frame counter. At every line frame boundary the read side compares the frames written with the frames read.
- When no new frame is available, the previous frame is sent again.
- When the writer has pulled ahead by two or more frames, the older frames are dropped.

A common slip pulse reports either event, and a separate pulse for each direction tells them apart.

In 24-channel mode the system frame is 193 bits. The bit on which the sync is strobed is a framing position and is thrown away. The following 192 bits fill the 24 line timeslots whose number is not a multiple of four. With the enable low, the store is bypassed.

Top module: `tx_elastic_store`

## Requirements
- R1: While rst_ni is low, line_data_o is 1 and line_fs_o, slip_o, slip_repeat_o and slip_delete_o are 0.
- R2: In 32-channel mode (t1_mode_i=0), a strobe with sys_sync_i high stores its bit as bit 0 of a frame. The next 255 strobed bits follow in order. A frame is output in the line frame after the one in which it completed. Output bit p of a frame appears on the line clock edge p cycles after the edge that raises line_fs_o; p = 8*timeslot + bit, first bit first.
- R3: Inputs in cycles with sys_valid_i low have no effect, including sys_sync_i. Strobed bits after the last bit of a frame and before the next sync are discarded.
- R4: A strobed sync arriving before a frame is complete discards the partial frame and starts a new frame at bit 0.
- R5: In 24-channel mode (t1_mode_i=1), the bit strobed with the sync is discarded. The next 192 strobed bits fill timeslots 1,2,3,5,6,7,…,31 in order, eight bits each. Timeslots 0,4,8,…,28 are output as all ones.
- R6: If no new complete frame is available at a line frame boundary, the previously output frame is repeated. slip_o and slip_repeat_o pulse for one line cycle together with line_fs_o. After reset, before any frame is complete, all-ones frames are output with this report.
- R7: If two or more unread complete frames exist at a line frame boundary, the newest complete frame is output and the older ones are dropped. slip_o and slip_delete_o pulse for one line cycle together with line_fs_o.
- R8: slip_repeat_o and slip_delete_o are never high together, and slip_o is high exactly when one of them is.
- R9: line_fs_o is high for one line cycle in every 256.
- R10: With en_i low, line_data_o equals sys_data_i sampled on the previous line clock edge, and no slip is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk_i | input | 1 | Fast system-side clock |
| line_clk_i | input | 1 | Line clock, one bit per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| en_i | input | 1 | 1: store active, 0: bypass (static) |
| t1_mode_i | input | 1 | 1: 24-channel system frame, 0: 32-channel (static) |
| sys_valid_i | input | 1 | Data-valid strobe, one bit per strobe |
| sys_sync_i | input | 1 | Frame sync, qualified by sys_valid_i |
| sys_data_i | input | 1 | System serial data |
| line_data_o | output | 1 | Line-side serial data |
| line_fs_o | output | 1 | High with bit 0 of each line frame |
| slip_o | output | 1 | Pulse on any controlled slip |
| slip_repeat_o | output | 1 | Pulse when a frame was repeated |
| slip_delete_o | output | 1 | Pulse when frames were dropped |

## Verification
Several internal faults show up at the next line frame boundary as a wrong slip pulse or a whole frame that matches no written frame:
- a corrupt write position or bank select;
- a frame counter that lost a step in the crossing;
- a wrong slip decision.

A fault in the 24-channel mapping shows as misplaced bytes or non-ones in the unfilled timeslots within the frame after the write. Every written frame carries a distinct pseudo-random pattern, so a frame from the wrong bank or in the wrong order is detected on its first differing bit. The bench checks each complete 256-bit frame against it.

// File: rtl/tes_pkg.sv
package tes_pkg;
  typedef enum logic [1:0] {
    DEC_NORMAL = 2'd0,
    DEC_REPEAT = 2'd1,
    DEC_DELETE = 2'd2
  } slip_dec_e;

  function automatic logic is_skip(input int unsigned ts, input int unsigned every);
    return (ts % every) == 0;
  endfunction
endpackage

// File: rtl/tes_write_ctl.sv
module tes_write_ctl #(
  parameter int unsigned TS_NUM     = 32,
  parameter int unsigned TS_BITS    = 8,
  parameter int unsigned SKIP_EVERY = 4,
  parameter int unsigned CNT_W      = 3,
  localparam int unsigned TS_W      = $clog2(TS_NUM),
  localparam int unsigned BIT_W     = $clog2(TS_BITS),
  localparam int unsigned ADDR_W    = 1 + TS_W + BIT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              t1_mode_i,
  input  logic              valid_i,
  input  logic              sync_i,
  input  logic              data_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              wdata_o,
  output logic [CNT_W-1:0]  wfc_gray_o
);
  logic             active_q;
  logic [TS_W-1:0]  ts_q, cur_ts, nxt_ts;
  logic [BIT_W-1:0] bit_q, cur_bit, nxt_bit;
  logic [CNT_W-1:0] wfc_q, wfc_n, gray_q;
  logic             start, take, last;

  assign start   = valid_i && sync_i;
  assign cur_ts  = start ? '0 : ts_q;
  assign cur_bit = start ? '0 : bit_q;
  // sync bit is a discarded framing position in 24-channel mode
  assign take    = valid_i && (start ? !t1_mode_i : active_q);
  assign last    = (cur_ts == TS_W'(TS_NUM - 1)) && (cur_bit == BIT_W'(TS_BITS - 1));
  assign wfc_n   = wfc_q + 1'b1;

  always_comb begin
    nxt_ts  = cur_ts;
    nxt_bit = cur_bit + 1'b1;
    if (cur_bit == BIT_W'(TS_BITS - 1)) begin
      nxt_bit = '0;
      nxt_ts  = cur_ts + 1'b1;
      if (t1_mode_i && tes_pkg::is_skip(32'(nxt_ts), SKIP_EVERY)) nxt_ts = nxt_ts + 1'b1;
    end
    if (start && t1_mode_i) begin
      nxt_ts  = TS_W'(1);
      nxt_bit = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ts_q     <= '0;
      bit_q    <= '0;
      wfc_q    <= '0;
      gray_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      ts_q     <= nxt_ts;
      bit_q    <= nxt_bit;
    end else if (take) begin
      if (last) begin
        active_q <= 1'b0;
        wfc_q    <= wfc_n;
        gray_q   <= wfc_n ^ (wfc_n >> 1);
      end else begin
        ts_q  <= nxt_ts;
        bit_q <= nxt_bit;
      end
    end
  end

  assign we_o       = take;
  assign waddr_o    = {wfc_q[0], cur_ts, cur_bit};
  assign wdata_o    = data_i;
  assign wfc_gray_o = gray_q;

  assert_t1_no_skip_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && t1_mode_i) |-> !tes_pkg::is_skip(32'(cur_ts), SKIP_EVERY));

  assert_gray_single_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/tes_store.sv
module tes_store #(
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              rdata_o
);
  logic [DEPTH-1:0] mem_q;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '1;
    else if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/tes_gray_sync.sv
module tes_gray_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= gray_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  always_comb begin
    bin_o[W-1] = stg_q[STAGES-1][W-1];
    for (int i = int'(W) - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ stg_q[STAGES-1][i];
  end
endmodule

// File: rtl/tes_read_ctl.sv
module tes_read_ctl #(
  parameter int unsigned TS_NUM     = 32,
  parameter int unsigned TS_BITS    = 8,
  parameter int unsigned SKIP_EVERY = 4,
  parameter int unsigned CNT_W      = 3,
  localparam int unsigned FRAME_BITS = TS_NUM * TS_BITS,
  localparam int unsigned POS_W     = $clog2(FRAME_BITS),
  localparam int unsigned BIT_W     = $clog2(TS_BITS),
  localparam int unsigned ADDR_W    = 1 + POS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              t1_mode_i,
  input  logic [CNT_W-1:0]  wfc_i,
  input  logic              bypass_data_i,
  input  logic              rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              data_o,
  output logic              fs_o,
  output logic              slip_o,
  output logic              rep_o,
  output logic              del_o
);
  import tes_pkg::*;

  logic [POS_W-1:0] rpos_q;
  logic             rbank_q, bank_sel, cur_bank, at_fs, fill;
  logic [CNT_W-1:0] rfc_q, rfc_n, avail;
  slip_dec_e        dec;

  assign at_fs = (rpos_q == '0);
  assign avail = wfc_i - rfc_q;

  always_comb begin
    dec      = DEC_NORMAL;
    bank_sel = rfc_q[0];
    rfc_n    = rfc_q + 1'b1;
    if (avail == '0) begin
      dec      = DEC_REPEAT;
      bank_sel = ~rfc_q[0];
      rfc_n    = rfc_q;
    end else if (avail != CNT_W'(1)) begin
      // newest complete frame is wfc-1
      dec      = DEC_DELETE;
      bank_sel = ~wfc_i[0];
      rfc_n    = wfc_i;
    end
  end

  assign cur_bank = at_fs ? bank_sel : rbank_q;
  assign raddr_o  = {cur_bank, rpos_q};
  assign fill     = t1_mode_i && is_skip(32'(rpos_q[POS_W-1:BIT_W]), SKIP_EVERY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rpos_q  <= '0;
      rbank_q <= 1'b1;
      rfc_q   <= '0;
      data_o  <= 1'b1;
      fs_o    <= 1'b0;
      slip_o  <= 1'b0;
      rep_o   <= 1'b0;
      del_o   <= 1'b0;
    end else begin
      rpos_q <= (rpos_q == POS_W'(FRAME_BITS - 1)) ? '0 : rpos_q + 1'b1;
      if (at_fs && en_i) begin
        rbank_q <= bank_sel;
        rfc_q   <= rfc_n;
      end
      data_o <= !en_i ? bypass_data_i : (fill ? 1'b1 : rdata_i);
      fs_o   <= at_fs;
      slip_o <= en_i && at_fs && (dec != DEC_NORMAL);
      rep_o  <= en_i && at_fs && (dec == DEC_REPEAT);
      del_o  <= en_i && at_fs && (dec == DEC_DELETE);
    end
  end

  assert_one_direction_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rep_o && del_o));

  assert_slip_matches_dir_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o == (rep_o || del_o));

  assert_slip_on_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_o || del_o) |-> fs_o);

  assert_bypass_no_slip_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !slip_o);
endmodule

// File: rtl/tx_elastic_store.sv
module tx_elastic_store #(
  parameter int unsigned TS_NUM      = 32,
  parameter int unsigned TS_BITS     = 8,
  parameter int unsigned SKIP_EVERY  = 4,
  parameter int unsigned CNT_W       = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned ADDR_W     = 1 + $clog2(TS_NUM * TS_BITS)
) (
  input  logic sys_clk_i,
  input  logic line_clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic t1_mode_i,
  input  logic sys_valid_i,
  input  logic sys_sync_i,
  input  logic sys_data_i,
  output logic line_data_o,
  output logic line_fs_o,
  output logic slip_o,
  output logic slip_repeat_o,
  output logic slip_delete_o
);
  logic              we, wdata, rdata;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [CNT_W-1:0]  wfc_gray, wfc_line;

  tes_write_ctl #(
    .TS_NUM(TS_NUM), .TS_BITS(TS_BITS), .SKIP_EVERY(SKIP_EVERY), .CNT_W(CNT_W)
  ) u_wr (
    .clk_i(sys_clk_i), .rst_ni(rst_ni), .t1_mode_i(t1_mode_i),
    .valid_i(sys_valid_i), .sync_i(sys_sync_i), .data_i(sys_data_i),
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .wfc_gray_o(wfc_gray)
  );

  tes_store #(.ADDR_W(ADDR_W)) u_mem (
    .wclk_i(sys_clk_i), .rst_ni(rst_ni), .we_i(we), .waddr_i(waddr),
    .wdata_i(wdata), .raddr_i(raddr), .rdata_o(rdata)
  );

  tes_gray_sync #(.W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(line_clk_i), .rst_ni(rst_ni), .gray_i(wfc_gray), .bin_o(wfc_line)
  );

  tes_read_ctl #(
    .TS_NUM(TS_NUM), .TS_BITS(TS_BITS), .SKIP_EVERY(SKIP_EVERY), .CNT_W(CNT_W)
  ) u_rd (
    .clk_i(line_clk_i), .rst_ni(rst_ni), .en_i(en_i), .t1_mode_i(t1_mode_i),
    .wfc_i(wfc_line), .bypass_data_i(sys_data_i), .rdata_i(rdata),
    .raddr_o(raddr), .data_o(line_data_o), .fs_o(line_fs_o),
    .slip_o(slip_o), .rep_o(slip_repeat_o), .del_o(slip_delete_o)
  );
endmodule

// File: tb/tb_tx_elastic_store.sv
module tb_tx_elastic_store;
  logic sys_clk = 1'b0, line_clk = 1'b0, rst_ni = 1'b0;
  logic en = 1'b1, t1 = 1'b0, valid = 1'b0, sync = 1'b0, data = 1'b0;
  logic line_data, line_fs, slip, slip_rep, slip_del;

  int checks = 0, fails = 0, next_id = 1;
  bit done = 1'b0;
  logic [255:0] pend_img;
  bit pend_rep, pend_del, pend_chk;
  string pend_tag;

  tx_elastic_store dut (
    .sys_clk_i(sys_clk), .line_clk_i(line_clk), .rst_ni(rst_ni), .en_i(en),
    .t1_mode_i(t1), .sys_valid_i(valid), .sys_sync_i(sync), .sys_data_i(data),
    .line_data_o(line_data), .line_fs_o(line_fs), .slip_o(slip),
    .slip_repeat_o(slip_rep), .slip_delete_o(slip_del)
  );

  always #2 sys_clk = ~sys_clk;   // 250 MHz
  always #8 line_clk = ~line_clk;

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit frm_bit(input int id, input int i);
    logic [31:0] x;
    x = 32'(id) * 32'h9E3779B1 ^ 32'(i) * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    x = x * 32'hC2B2AE35;
    x = x ^ (x >> 16);
    return x[0];
  endfunction

  function automatic logic [255:0] build_img(input int id, input bit t1m);
    logic [255:0] img;
    for (int p = 0; p < 256; p++) begin
      int ts = p / 8;
      int b = p % 8;
      if (!t1m) img[p] = frm_bit(id, p);
      else if (ts % 4 == 0) img[p] = 1'b1;
      else img[p] = frm_bit(id, (ts - ts / 4 - 1) * 8 + b);
    end
    return img;
  endfunction

  task automatic send_bit(input bit s, input bit d, input bit gaps);
    if (gaps) begin
      repeat ($urandom_range(0, 1)) begin
        @(negedge sys_clk);
        valid = 1'b0; sync = 1'($urandom); data = 1'($urandom);  // R3: ignored
      end
    end
    @(negedge sys_clk);
    valid = 1'b1; sync = s; data = d;
  endtask

  task automatic idle();
    @(negedge sys_clk);
    valid = 1'b0; sync = 1'b0; data = 1'b0;
  endtask

  task automatic write_frame(input int id, input bit t1m, input bit gaps, input int cnt);
    int n = (cnt > 0) ? cnt : (t1m ? 193 : 256);
    for (int i = 0; i < n; i++) begin
      bit d;
      if (t1m) d = (i == 0) ? 1'($urandom) : frm_bit(id, i - 1);
      else d = frm_bit(id, i);
      send_bit(i == 0, d, gaps);
    end
    idle();
  endtask

  task automatic step(input int kind, input int a, input int b, input bit t1m, input bit gaps,
                      input bit chk_data);
    logic [255:0] img;
    bit rep, del, slp;
    int fs_err = 0;
    do @(negedge line_clk); while (!line_fs);
    rep = slip_rep; del = slip_del; slp = slip; img[0] = line_data;
    fork
      begin
        case (kind)
          1: write_frame(a, t1m, gaps, 0);
          2: begin write_frame(a, t1m, 1'b0, 0); write_frame(b, t1m, 1'b0, 0); end
          3: begin write_frame(b, t1m, 1'b0, 100); write_frame(a, t1m, 1'b0, 0); end
          4: begin
            write_frame(a, t1m, gaps, 0);
            for (int k = 0; k < 20; k++) send_bit(1'b0, 1'($urandom), 1'b0);
            idle();
          end
          default: ;
        endcase
      end
      begin
        for (int p = 1; p < 256; p++) begin
          @(negedge line_clk);
          img[p] = line_data;
          if (line_fs) fs_err++;
        end
      end
    join
    if (chk_data) chk(img == pend_img, pend_tag, img, pend_img);
    chk(rep == pend_rep, "R6 repeat flag", 256'(rep), 256'(pend_rep));
    chk(del == pend_del, "R7 delete flag", 256'(del), 256'(pend_del));
    chk(slp == (pend_rep | pend_del), "R8 slip flag", 256'(slp), 256'(pend_rep | pend_del));
    chk(fs_err == 0, "R9 frame pulse spacing", 256'(fs_err), 256'(0));
  endtask

  task automatic run(input int kind, input bit t1m, input bit gaps, input string tag);
    int a = next_id;
    int b = next_id + 1;
    next_id += 2;
    step(kind, a, b, t1m, gaps, pend_chk && kind != 2);
    case (kind)
      0: begin pend_rep = 1'b1; pend_del = 1'b0; pend_tag = "R6 repeated frame"; end
      2: begin pend_img = build_img(b, t1m); pend_rep = 1'b0; pend_del = 1'b1;
               pend_chk = 1'b1; pend_tag = "R7 newest frame kept"; end
      default: begin pend_img = build_img(a, t1m); pend_rep = 1'b0; pend_del = 1'b0;
                     pend_chk = 1'b1; pend_tag = tag; end
    endcase
  endtask

  task automatic do_reset(input bit en_v, input bit t1_v);
    rst_ni = 1'b0; en = en_v; t1 = t1_v;
    valid = 1'b0; sync = 1'b0; data = 1'b0;
    repeat (3) @(negedge line_clk);
    chk(line_data == 1'b1, "R1 reset data", 256'(line_data), 256'(1));
    chk({line_fs, slip, slip_rep, slip_del} == 4'b0, "R1 reset flags",
        256'({line_fs, slip, slip_rep, slip_del}), 256'(0));
    @(negedge line_clk);
    #1 rst_ni = 1'b1;
    pend_img = '1; pend_rep = 1'b1; pend_del = 1'b0; pend_chk = 1'b1;
    pend_tag = "R6 startup all ones";
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // 32-channel session
    do_reset(1'b1, 1'b0);
    run(1, 0, 1, "R2 in-order frame");
    run(1, 0, 1, "R2 in-order frame");
    run(4, 0, 1, "R3 extra strobes ignored");
    run(1, 0, 0, "R2 in-order frame");
    run(3, 0, 1, "R4 restart on early sync");
    run(1, 0, 1, "R2 in-order frame");
    run(0, 0, 1, "");                        // underflow: R6
    run(1, 0, 1, "R2 in-order frame");
    run(2, 0, 0, "");                        // overflow: R7
    run(1, 0, 1, "R2 in-order frame");
    for (int k = 0; k < 8; k++) begin
      int r = $urandom_range(0, 9);
      run((r < 6) ? 1 : (r < 8) ? 0 : 2, 0, 1, "R2 random frame");
    end
    run(1, 0, 1, "R2 in-order frame");
    run(1, 0, 1, "R2 in-order frame");
    // 24-channel session
    do_reset(1'b1, 1'b1);
    run(1, 1, 1, "R5 24-channel mapping");
    run(1, 1, 0, "R5 24-channel mapping");
    run(3, 1, 1, "R5 24-channel after restart");
    run(0, 1, 1, "");
    run(1, 1, 1, "R5 24-channel mapping");
    run(1, 1, 1, "R5 24-channel mapping");
    // bypass session
    do_reset(1'b0, 1'b0);
    for (int k = 0; k < 24; k++) begin
      bit d = 1'($urandom);
      @(negedge line_clk);
      data = d;
      @(negedge line_clk);
      chk(line_data == d, "R10 bypass data", 256'(line_data), 256'(d));
      chk(slip == 1'b0, "R10 bypass no slip", 256'(slip), 256'(0));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=hung expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule